// File: doc/BRIEF.md
# Multi-Channel DMA Start Gate

This block sits between the register-write path of a ten-channel DMA controller and the channel transfer engines. It holds each channel's 32-bit control word. The word has a start/busy flag in bit 8, a mode half in bits 15:0 and a tag half in bits 31:16. The block decides whether a write to that word may launch the channel at once. When it may not, the block parks the start in a per-channel pending bit.

Two global levels gate every start: the controller enable and the controller suspend. A start can go out only while enable is 1 and suspend is 0. When enable rises, or when suspend falls, every parked channel that is now allowed to run is launched in the same cycle. A busy channel is protected. While the controller runs, such a channel accepts only a force-stop. While the controller is suspended, it accepts new mode bits but keeps its tag.

Top module: `dsg_top`

## Requirements
- R1: After reset every control word, every pending bit and every launch and interrupt-clear pulse is zero.
- R2: A write that sets the start flag (bit 8) of an idle channel, while enable is 1 and suspend is 0, gives a one-cycle `launch` pulse for that channel in the next cycle. It also leaves the channel's pending bit clear.
- R3: A write that sets the start flag of an idle channel while enable is 0 or suspend is 1 sets the channel's pending bit and gives no launch pulse.
- R4: A busy channel written while suspend is 0 ignores any gated write whose start value is 1, so its control word does not change. A gated write whose start value is 0 clears only bit 8, clears the pending bit and pulses `irq_clear` for that channel.
- R5: A busy channel written while suspend is 1 takes the new bits 15:0 and keeps bits 31:16. If the new start value is 0, the write also clears the pending bit and pulses `irq_clear`.
- R6: On an idle channel a word write (`wr_size`=2) replaces all 32 bits. A half write (`wr_size`=1) with `wr_lane[1]`=0 replaces only bits 15:0 and keeps the tag. A half write with `wr_lane[1]`=1 writes the tag directly.
- R7: A byte write (`wr_size`=0) to lane 1 changes only bit 8, which takes `wr_data[0]`, and follows the gating rules of R2 to R5. A byte write to lanes 0, 2 or 3 stores `wr_data[7:0]` into that byte with no gating.
- R8: In the cycle after enable rises or suspend falls, every channel that is pending, while enable is 1 and suspend is 0, gives one `launch` pulse and its pending bit clears. Channels that still may not run stay pending.
- R9: A write to a channel in the same cycle as a replay trigger is handled as a write, and that channel is not replayed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_chan | input | 4 | Channel selected by the write |
| wr_size | input | 2 | 0 byte, 1 half, 2 word |
| wr_lane | input | 2 | Byte lane (byte writes) or half select in bit 1 (half writes) |
| wr_data | input | 32 | Write data, right-aligned for byte and half writes |
| dma_enable | input | 1 | Global controller enable level |
| dma_suspend | input | 1 | Global controller suspend level |
| rd_chan | input | 4 | Channel whose control word is shown on `rd_data` |
| rd_data | output | 32 | Control word of `rd_chan` |
| launch | output | 10 | One-cycle start pulse per channel |
| irq_clear | output | 10 | One-cycle interrupt-clear pulse per channel |
| pending | output | 10 | Parked start request per channel |

## Verification
`launch`, `irq_clear` and `pending` are registered. Each is due exactly one rising edge after the write, or after the enable or suspend change, that caused it. `rd_data` is a combinational view of the stored word, so it shows the effect of a write after that same edge. The bench drives all inputs on the falling edge. It samples every output at the next falling edge, so each result is compared in the one cycle where it is valid, and a launch pulse that comes late or lasts two cycles is caught.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

  localparam int CTRL_W    = 32;
  localparam int START_BIT = 8;
  localparam int HALF_W    = CTRL_W / 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } wr_size_e;

  typedef struct packed {
    logic [CTRL_W-1:0] word;
    logic              arm;
    logic              stop;
  } wr_result_t;

  // True when the write goes through the busy/idle gating rules.
  function automatic logic is_gated(input logic [1:0] size, input logic [1:0] lane);
    case (size)
      SZ_BYTE: is_gated = (lane == 2'd1);
      SZ_HALF: is_gated = !lane[1];
      SZ_WORD: is_gated = 1'b1;
      default: is_gated = 1'b0;
    endcase
  endfunction

  // Start value carried by a gated write.
  function automatic logic new_start(input logic [1:0] size, input logic [CTRL_W-1:0] data);
    new_start = (size == SZ_BYTE) ? data[0] : data[START_BIT];
  endfunction

  function automatic wr_result_t apply_write(
    input logic [CTRL_W-1:0] cur,
    input logic [1:0]        size,
    input logic [1:0]        lane,
    input logic [CTRL_W-1:0] data,
    input logic              suspended
  );
    wr_result_t        r;
    logic              busy;
    logic              ns;
    logic [HALF_W-1:0] low_new;
    r       = '{word: cur, arm: 1'b0, stop: 1'b0};
    busy    = cur[START_BIT];
    ns      = new_start(size, data);
    low_new = cur[HALF_W-1:0];
    if (size == SZ_BYTE) low_new[START_BIT] = data[0];
    else                 low_new = data[HALF_W-1:0];

    if (!is_gated(size, lane)) begin
      if (size == SZ_BYTE)      r.word[{lane, 3'b000} +: 8] = data[7:0];
      else if (size == SZ_HALF) r.word[CTRL_W-1:HALF_W]     = data[HALF_W-1:0];
    end else if (busy) begin
      if (suspended) begin
        r.word[HALF_W-1:0] = low_new;
        r.stop             = !ns;
      end else if (!ns) begin
        r.word[START_BIT] = 1'b0;
        r.stop            = 1'b1;
      end
    end else begin
      if (size == SZ_WORD) r.word = data;
      else                 r.word[HALF_W-1:0] = low_new;
      r.arm = ns;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsg_global_edge.sv
module dsg_global_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_enable,
  input  logic dma_suspend,
  output logic go,
  output logic replay_trig
);

  logic en_q;
  logic sus_q;
  logic en_rise;
  logic sus_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sus_q <= 1'b0;
    end else begin
      en_q  <= dma_enable;
      sus_q <= dma_suspend;
    end
  end

  assign en_rise     = dma_enable & ~en_q;
  assign sus_fall    = ~dma_suspend & sus_q;
  assign go          = dma_enable & ~dma_suspend;
  assign replay_trig = en_rise | sus_fall;

  // R8: a replay trigger can only follow a change of a global level
  assert_trig_from_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    replay_trig |-> (dma_enable != en_q) || (dma_suspend != sus_q));

endmodule

// File: rtl/dsg_chan_slot.sv
module dsg_chan_slot
  import dsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [1:0]        wr_size,
  input  logic [1:0]        wr_lane,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              suspended,
  input  logic              go,
  input  logic              replay_trig,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              launch_o,
  output logic              irq_clr_o,
  output logic              pend_o
);

  logic [CTRL_W-1:0] ctrl_q;
  logic              launch_q;
  logic              irq_q;
  logic              pend_q;
  wr_result_t        res;
  logic              gated_wr;
  logic              busy_gated_wr;
  logic              ignored_wr;

  assign res           = apply_write(ctrl_q, wr_size, wr_lane, wr_data, suspended);
  assign gated_wr      = wr_hit && is_gated(wr_size, wr_lane);
  assign busy_gated_wr = gated_wr && ctrl_q[START_BIT];
  assign ignored_wr    = busy_gated_wr && !suspended && new_start(wr_size, wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      launch_q <= 1'b0;
      irq_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      launch_q <= 1'b0;
      irq_q    <= 1'b0;
      if (wr_hit) begin
        ctrl_q <= res.word;
        irq_q  <= res.stop;
        if (res.stop) begin
          pend_q <= 1'b0;
        end else if (res.arm) begin
          launch_q <= go;
          pend_q   <= ~go;
        end
      end else if (replay_trig && pend_q && go) begin
        launch_q <= 1'b1;
        pend_q   <= 1'b0;
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign launch_o  = launch_q;
  assign irq_clr_o = irq_q;
  assign pend_o    = pend_q;

  // R2: a launch only follows a cycle in which the controller was allowed to run
  assert_launch_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |-> $past(go));

  // R3: a parked request always belongs to a channel with its start flag set
  assert_pend_has_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> ctrl_q[START_BIT]);

  // R4: an ignored write to a running busy channel leaves the word untouched
  assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_wr |=> $stable(ctrl_q));

  // R4: a stop pulse leaves the channel idle and not pending
  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (!pend_q && !ctrl_q[START_BIT]));

  // R5: gated writes to a busy channel never alter the tag half
  assert_tag_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_gated_wr |=> $stable(ctrl_q[CTRL_W-1:HALF_W]));

  // R8: a launch not caused by a write must come from a replay trigger
  assert_replay_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_q && !$past(wr_hit)) |-> $past(replay_trig));

  // R8: a launched channel is no longer pending
  assert_launch_clears_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |-> !pend_q);

endmodule

// File: rtl/dsg_top.sv
module dsg_top
  import dsg_pkg::*;
#(
  parameter int NCH = 10,
  localparam int CW = (NCH > 1) ? $clog2(NCH + 1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_chan,
  input  logic [1:0]        wr_size,
  input  logic [1:0]        wr_lane,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              dma_enable,
  input  logic              dma_suspend,
  input  logic [CW-1:0]     rd_chan,
  output logic [CTRL_W-1:0] rd_data,
  output logic [NCH-1:0]    launch,
  output logic [NCH-1:0]    irq_clear,
  output logic [NCH-1:0]    pending
);

  logic              go;
  logic              replay_trig;
  logic [CTRL_W-1:0] ctrl [NCH];
  logic [NCH-1:0]    wr_hit;

  dsg_global_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_enable  (dma_enable),
    .dma_suspend (dma_suspend),
    .go          (go),
    .replay_trig (replay_trig)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign wr_hit[i] = wr_en && (wr_chan == CW'(i));

    dsg_chan_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_hit      (wr_hit[i]),
      .wr_size     (wr_size),
      .wr_lane     (wr_lane),
      .wr_data     (wr_data),
      .suspended   (dma_suspend),
      .go          (go),
      .replay_trig (replay_trig),
      .ctrl_o      (ctrl[i]),
      .launch_o    (launch[i]),
      .irq_clr_o   (irq_clear[i]),
      .pend_o      (pending[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_chan == CW'(i)) rd_data = ctrl[i];
    end
  end

  // R1: outputs come up clear on the first cycle after reset is released
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (launch == '0 && pending == '0 && irq_clear == '0));

  // R9: at most the written channel can see a stop pulse in one cycle
  assert_single_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_clear) <= 1);

endmodule

// File: tb/test_dsg_top.sv
module test_dsg_top;

  localparam int NCH = 10;
  localparam int CW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [CW-1:0] wr_chan = '0;
  logic [1:0]    wr_size = '0;
  logic [1:0]    wr_lane = '0;
  logic [31:0]   wr_data = '0;
  logic          dma_enable = 1'b0;
  logic          dma_suspend = 1'b0;
  logic [CW-1:0] rd_chan = '0;
  logic [31:0]   rd_data;
  logic [NCH-1:0] launch, irq_clear, pending;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // expected state
  logic [31:0]    m_reg [NCH];
  logic [NCH-1:0] m_pend;
  logic [NCH-1:0] m_launch, m_irq;
  logic           p_en, p_sus;

  dsg_top #(.NCH(NCH)) i_dsg_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_size(wr_size), .wr_lane(wr_lane), .wr_data(wr_data),
    .dma_enable(dma_enable), .dma_suspend(dma_suspend),
    .rd_chan(rd_chan), .rd_data(rd_data),
    .launch(launch), .irq_clear(irq_clear), .pending(pending)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected effect of one write on channel c, stated from the requirements.
  task automatic model_write(input int c, input logic go_now);
    logic        busy, s;
    logic [31:0] cur;
    cur  = m_reg[c];
    busy = cur[8];
    if (wr_size == 2'd0 && wr_lane != 2'd1) begin
      case (wr_lane)
        2'd0:    cur[7:0]   = wr_data[7:0];
        2'd2:    cur[23:16] = wr_data[7:0];
        default: cur[31:24] = wr_data[7:0];
      endcase
    end else if (wr_size == 2'd1 && wr_lane[1]) begin
      cur[31:16] = wr_data[15:0];
    end else if (wr_size <= 2'd2) begin
      s = (wr_size == 2'd0) ? wr_data[0] : wr_data[8];
      if (busy && !dma_suspend) begin
        if (!s) begin
          cur[8] = 1'b0; m_pend[c] = 1'b0; m_irq[c] = 1'b1;
        end
      end else if (busy) begin
        if (wr_size == 2'd0) cur[8] = s;
        else cur[15:0] = wr_data[15:0];
        if (!s) begin m_pend[c] = 1'b0; m_irq[c] = 1'b1; end
      end else begin
        if (wr_size == 2'd2) cur = wr_data;
        else if (wr_size == 2'd1) cur[15:0] = wr_data[15:0];
        else cur[8] = s;
        if (s) begin
          if (go_now) begin m_launch[c] = 1'b1; m_pend[c] = 1'b0; end
          else m_pend[c] = 1'b1;
        end
      end
    end
    m_reg[c] = cur;
  endtask

  // One clock: inputs already set; predict, clock, compare.
  task automatic step(input string tag);
    logic go_now, trig;
    go_now   = dma_enable && !dma_suspend;
    trig     = (dma_enable && !p_en) || (!dma_suspend && p_sus);
    m_launch = '0;
    m_irq    = '0;
    for (int c = 0; c < NCH; c++) begin
      if (wr_en && wr_chan == CW'(c)) model_write(c, go_now);
      else if (trig && go_now && m_pend[c]) begin
        m_launch[c] = 1'b1;
        m_pend[c]   = 1'b0;
      end
    end
    p_en  = dma_enable;
    p_sus = dma_suspend;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " launch"},  32'(launch),    32'(m_launch));
    chk({tag, " irq"},     32'(irq_clear), 32'(m_irq));
    chk({tag, " pending"}, 32'(pending),   32'(m_pend));
    chk({tag, " rd_data"}, rd_data,        m_reg[rd_chan]);
  endtask

  task automatic wr(input int c, input logic [1:0] sz, input logic [1:0] ln,
                    input logic [31:0] d, input string tag);
    wr_en = 1'b1; wr_chan = CW'(c); wr_size = sz; wr_lane = ln; wr_data = d;
    rd_chan = CW'(c);
    step(tag);
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) m_reg[c] = '0;
    m_pend = '0; p_en = 0; p_sus = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 launch", 32'(launch), 0);
    chk("R1 pending", 32'(pending), 0);
    chk("R1 irq", 32'(irq_clear), 0);
    for (int c = 0; c < NCH; c++) begin
      rd_chan = CW'(c);
      #1 chk("R1 rd_data", rd_data, 0);
    end

    // R2 / R6: idle word write with controller running
    dma_enable = 1'b1; step("R8 enable with nothing pending");
    wr(3, 2'd2, 2'd0, 32'hABCD_0100, "R2 idle launch");
    chk("R2 launch ch3", 32'(launch), 32'h8);
    chk("R6 word write", rd_data, 32'hABCD_0100);
    step("R2 single pulse");
    chk("R2 pulse gone", 32'(launch), 0);

    // R4: busy, running
    wr(3, 2'd2, 2'd0, 32'h5555_0155, "R4 busy ignore");
    chk("R4 unchanged", rd_data, 32'hABCD_0100);
    wr(3, 2'd2, 2'd0, 32'h1234_0000, "R4 force stop");
    chk("R4 only start cleared", rd_data, 32'hABCD_0000);
    chk("R4 irq ch3", 32'(irq_clear), 32'h8);

    // R6: idle half write keeps tag
    wr(3, 2'd1, 2'd0, 32'h0000_0042, "R6 half lower");
    chk("R6 tag kept", rd_data, 32'hABCD_0042);

    // R3 / R7: starts while disabled are parked
    dma_enable = 1'b0;
    wr(5, 2'd1, 2'd0, 32'h0000_0100, "R3 park half");
    wr(7, 2'd0, 2'd1, 32'h0000_0001, "R7 byte start");
    chk("R7 only bit8", rd_data, 32'h0000_0100);
    wr(6, 2'd0, 2'd2, 32'h0000_00EE, "R7 raw byte");
    chk("R7 raw lane2", rd_data, 32'h00EE_0000);
    chk("R3 pending", 32'(pending), 32'hA0);

    // R8: enable rise replays all in one cycle
    dma_enable = 1'b1; step("R8 replay");
    chk("R8 launch both", 32'(launch), 32'hA0);
    chk("R8 pending cleared", 32'(pending), 0);

    // R5: busy while suspended
    dma_suspend = 1'b1;
    wr(0, 2'd2, 2'd0, 32'h00AA_0100, "R3 park suspended");
    wr(0, 2'd1, 2'd0, 32'h0000_0033, "R5 suspended stop");
    chk("R5 lower taken tag kept", rd_data, 32'h00AA_0033);
    chk("R5 irq ch0", 32'(irq_clear), 32'h1);
    wr(1, 2'd2, 2'd0, 32'h0001_0100, "R3 park ch1");
    wr(2, 2'd2, 2'd0, 32'h0002_0100, "R3 park ch2");

    // R9: suspend falls with a stop write on ch2 in the same cycle
    dma_suspend = 1'b0;
    wr(2, 2'd1, 2'd0, 32'h0000_0000, "R9 write priority");
    chk("R9 launch ch1 only", 32'(launch), 32'h2);
    chk("R9 irq ch2", 32'(irq_clear), 32'h4);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) dma_enable  = ~dma_enable;
      if ($urandom_range(7) == 0) dma_suspend = ~dma_suspend;
      wr_en   = ($urandom_range(9) < 6);
      wr_chan = CW'($urandom_range(NCH - 1));
      wr_size = 2'($urandom_range(2));
      wr_lane = ($urandom_range(1) == 0) ? 2'd1 : 2'($urandom_range(3));
      wr_data = $urandom;
      rd_chan = CW'($urandom_range(NCH - 1));
      step("R8 random mix");
    end
    wr_en = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule